// File: doc/BRIEF.md
# Command Stream Decoder

This block turns a stream of 32-bit command words into a sequence of register writes. Each write carries a method address, a subchannel number and a data value. Software or an upstream fetch unit first states how many words the command list holds. It does this by pulsing `start` with the word count while the block is idle. The fetch unit then presents the words on a valid/ready input. The block reads a header word, then takes the argument words that follow it. Each argument becomes one write, and the header's mode decides which method address that write is sent to. Writes leave through a single registered valid/ready output.

A header packs four fields. The method sits in bits 12:0 and the subchannel in bits 15:13. Bits 28:16 hold the argument count, or the immediate value in inline mode. The mode sits in bits 31:29. Headers that cannot be acted on raise one-cycle error pulses and are skipped, and decoding goes on with the next word. If the word budget runs out partway through a packet, the block flags the truncation and returns to idle.

Top module: `cmd_stream_decoder`

## Requirements
- R1: A header with mode 0 or 1 and count N>0 consumes the next N words. Argument i (counting from 0) is written to the header method plus i, modulo 2^13, with the header subchannel and the argument word as data.
- R2: A header with mode 2 or 3 and count N>0 writes all N arguments to the header method.
- R3: A header with mode 5 and count N>0 writes argument 0 to the header method and every later argument to the header method plus 1.
- R4: A header with mode 4 produces exactly one write to the header method. Its data is bits 28:16 of the header, zero-extended. The header consumes no argument words, so the next word is a header.
- R5: A header with mode 0 to 3 and count 0 produces no write, and the next word is a header.
- R6: A header with mode 5 and count 0 produces no write and raises `err_zero` for exactly one cycle.
- R7: A header with mode 6 or 7 produces no write and raises `err_mode` for one cycle. Its count field is ignored, and the next word is treated as a header.
- R8: After `start` with length L, exactly L input words are accepted. `in_ready` stays low outside that budget, and `busy` falls once the last write has left. A start with length 0 leaves the block idle.
- R9: If the budget ends while a packet still expects arguments, `err_trunc` pulses for one cycle and the block returns to idle. This applies whether the budget ends on the header or on an argument.
- R10: While `out_valid` is high and `out_ready` is low, the output write holds stable and no input word is accepted. No write is lost or duplicated under any pattern of backpressure.
- R11: After reset, `out_valid`, `in_ready`, `busy` and all error flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a command list (honoured only when idle) |
| start_len | input | LEN_W | Length of the command list in words |
| busy | output | 1 | Command list in progress or write still pending |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Input command word |
| in_ready | output | 1 | Input word accepted when high with `in_valid` |
| out_valid | output | 1 | Register write valid |
| out_method | output | 13 | Method address of the write |
| out_subch | output | 3 | Subchannel of the write |
| out_data | output | 32 | Data of the write |
| out_ready | input | 1 | Downstream takes the write |
| err_mode | output | 1 | One-cycle pulse: unimplemented mode skipped |
| err_zero | output | 1 | One-cycle pulse: mode 5 header with zero count |
| err_trunc | output | 1 | One-cycle pulse: budget ended inside a packet |

## Verification
Two things can fall in the same clock edge: the downstream taking the pending write, and the decoder accepting the next input word and loading a new write into the same output register. With `out_ready` held high, the mixed-mode command list runs back to back, so every edge drains one write and refills the register. The same list is then replayed with `out_ready` driven by a pseudo-random bit sequence, and a directed test releases a stalled write in the same cycle that a new inline header arrives. In every case the collected write sequence must match the expected list exactly, with nothing missing or repeated.

// File: rtl/cmdp_pkg.sv
// Shared field layout and types for the command stream decoder.
// Assumes a 32-bit command word; the field order inside the header is fixed
// because the upstream producer encodes it that way.
package cmdp_pkg;
    localparam int METH_W = 13;
    localparam int SUB_W  = 3;
    localparam int CNT_W  = 13;
    localparam int MODE_W = 3;
    localparam int WORD_W = METH_W + SUB_W + CNT_W + MODE_W;

    localparam logic [MODE_W-1:0] MODE_INLINE = 3'd4;
    localparam logic [MODE_W-1:0] MODE_ONCE   = 3'd5;
    localparam logic [MODE_W-1:0] MODE_LAST   = 3'd5;

    // Header fields, most significant first
    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [CNT_W-1:0]  cnt;
        logic [SUB_W-1:0]  sub;
        logic [METH_W-1:0] meth;
    } hdr_t;

    // How the method address advances across arguments
    typedef enum logic [1:0] {
        STEP_ALL  = 2'd0,
        STEP_NONE = 2'd1,
        STEP_ONCE = 2'd2
    } step_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HEAD = 2'd1,
        PH_ARGS = 2'd2
    } phase_e;

    // Map a legal non-inline mode to its addressing step
    function automatic step_e mode_step(input logic [MODE_W-1:0] m);
        if (m == MODE_ONCE)     return STEP_ONCE;
        else if (m[1])          return STEP_NONE;
        else                    return STEP_ALL;
    endfunction
endpackage

// File: rtl/cmdp_budget.sv
// Word budget counter: loaded with the list length, decremented per word.
// Assumes load and decrement never coincide (load only happens when idle).
module cmdp_budget #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] load_val,
    input  logic             dec,
    output logic             empty,
    output logic             last
);
    logic [LEN_W-1:0] rem_q;

    // Track words still to be consumed
    always_ff @(posedge clk) begin
        if (!rst_n)      rem_q <= '0;
        else if (load)   rem_q <= load_val;
        else if (dec)    rem_q <= rem_q - 1'b1;
    end

    assign empty = (rem_q == '0);
    assign last  = (rem_q == LEN_W'(1));

    // R8
    budget_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> !empty);
endmodule

// File: rtl/cmdp_addr_gen.sv
// Method address generator: derives the target method of argument idx from
// the header method and the addressing step. Purely combinational; the
// result wraps within the method field width.
module cmdp_addr_gen
    import cmdp_pkg::*;
(
    input  logic [METH_W-1:0] base,
    input  step_e             step,
    input  logic [CNT_W-1:0]  idx,
    output logic [METH_W-1:0] meth
);
    // Select the offset applied to the header method
    always_comb begin
        case (step)
            STEP_ALL:  meth = base + METH_W'(idx);
            STEP_ONCE: meth = base + METH_W'(idx != '0);
            default:   meth = base;
        endcase
    end
endmodule

// File: rtl/cmdp_out_slot.sv
// Single-entry output register for register writes. A new write may load in
// the same cycle the previous one is taken. Assumes the caller only loads
// when `free` is high.
module cmdp_out_slot
    import cmdp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [METH_W-1:0] ld_meth,
    input  logic [SUB_W-1:0]  ld_sub,
    input  logic [WORD_W-1:0] ld_data,
    input  logic              out_ready,
    output logic              free,
    output logic              out_valid,
    output logic [METH_W-1:0] out_method,
    output logic [SUB_W-1:0]  out_subch,
    output logic [WORD_W-1:0] out_data
);
    assign free = !out_valid || out_ready;

    // Hold a write until taken, refill on load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_method <= '0;
            out_subch  <= '0;
            out_data   <= '0;
        end else if (load) begin
            out_valid  <= 1'b1;
            out_method <= ld_meth;
            out_subch  <= ld_sub;
            out_data   <= ld_data;
        end else if (out_ready) begin
            out_valid  <= 1'b0;
        end
    end

    // R10
    no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (!out_valid || out_ready));

    // R10
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_method)
                                       && $stable(out_subch) && $stable(out_data)));
endmodule

// File: rtl/cmd_stream_decoder.sv
// Command stream decoder top: parses header words, walks the argument words
// per submission mode and issues one register write per argument (or one
// for an inline header). Assumes start is only meaningful when idle; input
// acceptance stalls whenever the output register cannot take a write.
module cmd_stream_decoder
    import cmdp_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  start_len,
    output logic              busy,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [METH_W-1:0] out_method,
    output logic [SUB_W-1:0]  out_subch,
    output logic [WORD_W-1:0] out_data,
    input  logic              out_ready,
    output logic              err_mode,
    output logic              err_zero,
    output logic              err_trunc
);
    phase_e            phase_q;
    logic [METH_W-1:0] base_q;
    logic [SUB_W-1:0]  sub_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  idx_q;
    step_e             step_q;

    logic              bud_empty, bud_last, slot_free, take;
    logic              at_head, at_args, is_inline, is_bad, is_zero;
    logic              go_args, last_arg, trunc_now, ld, start_ok;
    logic [METH_W-1:0] arg_meth, ld_meth;
    logic [SUB_W-1:0]  ld_sub;
    logic [WORD_W-1:0] ld_data;
    hdr_t              hdr;

    assign hdr       = hdr_t'(in_data);
    assign at_head   = (phase_q == PH_HEAD);
    assign at_args   = (phase_q == PH_ARGS);
    assign start_ok  = (phase_q == PH_IDLE) && start && (start_len != '0);
    assign in_ready  = (at_head || at_args) && !bud_empty && slot_free;
    assign take      = in_valid && in_ready;

    // Header classification
    assign is_inline = (hdr.mode == MODE_INLINE);
    assign is_bad    = (hdr.mode > MODE_LAST);
    assign is_zero   = (hdr.cnt == '0);
    assign go_args   = take && at_head && !is_inline && !is_bad && !is_zero;
    assign last_arg  = (idx_q == cnt_q - 1'b1);
    assign trunc_now = bud_last && ((go_args) || (take && at_args && !last_arg));

    cmdp_budget #(.LEN_W(LEN_W)) u_budget (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start_ok),
        .load_val (start_len),
        .dec      (take),
        .empty    (bud_empty),
        .last     (bud_last)
    );

    cmdp_addr_gen u_addr (
        .base (base_q),
        .step (step_q),
        .idx  (idx_q),
        .meth (arg_meth)
    );

    // Choose what gets written this cycle
    always_comb begin
        ld      = 1'b0;
        ld_meth = arg_meth;
        ld_sub  = sub_q;
        ld_data = in_data;
        if (take && at_head && is_inline) begin
            ld      = 1'b1;
            ld_meth = hdr.meth;
            ld_sub  = hdr.sub;
            ld_data = WORD_W'(hdr.cnt);
        end else if (take && at_args) begin
            ld      = 1'b1;
        end
    end

    cmdp_out_slot u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (ld),
        .ld_meth    (ld_meth),
        .ld_sub     (ld_sub),
        .ld_data    (ld_data),
        .out_ready  (out_ready),
        .free       (slot_free),
        .out_valid  (out_valid),
        .out_method (out_method),
        .out_subch  (out_subch),
        .out_data   (out_data)
    );

    // Phase sequencing across headers, arguments and list end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else begin
            case (phase_q)
                PH_IDLE: if (start_ok) phase_q <= PH_HEAD;
                PH_HEAD: if (take) begin
                    if (bud_last)     phase_q <= PH_IDLE;
                    else if (go_args) phase_q <= PH_ARGS;
                end
                PH_ARGS: if (take) begin
                    if (bud_last)      phase_q <= PH_IDLE;
                    else if (last_arg) phase_q <= PH_HEAD;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // Latch packet context on a header, advance the argument index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            sub_q  <= '0;
            cnt_q  <= '0;
            idx_q  <= '0;
            step_q <= STEP_ALL;
        end else if (go_args) begin
            base_q <= hdr.meth;
            sub_q  <= hdr.sub;
            cnt_q  <= hdr.cnt;
            idx_q  <= '0;
            step_q <= mode_step(hdr.mode);
        end else if (take && at_args) begin
            idx_q  <= idx_q + 1'b1;
        end
    end

    // One-cycle error pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_mode  <= 1'b0;
            err_zero  <= 1'b0;
            err_trunc <= 1'b0;
        end else begin
            err_mode  <= take && at_head && is_bad;
            err_zero  <= take && at_head && (hdr.mode == MODE_ONCE) && is_zero;
            err_trunc <= trunc_now;
        end
    end

    assign busy = (phase_q != PH_IDLE) || out_valid;

    // R6 R7 R9
    single_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({err_mode, err_zero, err_trunc}));

    // R9
    trunc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_trunc |-> (phase_q == PH_IDLE));

    // R4 R6 R7
    no_write_on_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_mode || err_zero) |-> !$rose(out_valid));

    // R8
    idle_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_IDLE) |-> !in_ready);
endmodule

// File: tb/cmd_stream_decoder_test.sv
module cmd_stream_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] start_len = '0;
    logic        busy, in_ready, out_valid, err_mode, err_zero, err_trunc;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        out_ready = 1'b1;
    logic [12:0] out_method;
    logic [2:0]  out_subch;
    logic [31:0] out_data;

    int checks = 0;
    int errors = 0;
    int n_mode = 0, n_zero = 0, n_trunc = 0;
    logic        mon_en = 1'b0;
    logic [47:0] got[$];
    logic [31:0] feed_q[$];

    always #5 clk = ~clk;

    cmd_stream_decoder uut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_len(start_len), .busy(busy),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_method(out_method), .out_subch(out_subch),
        .out_data(out_data), .out_ready(out_ready),
        .err_mode(err_mode), .err_zero(err_zero), .err_trunc(err_trunc));

    function automatic logic [31:0] H(input int mode, input int cnt, input int sub, input int meth);
        return {mode[2:0], cnt[12:0], sub[2:0], meth[12:0]};
    endfunction
    function automatic logic [31:0] A(input int k);
        return 32'hC0DE_0000 + k;
    endfunction
    function automatic logic [47:0] E(input int meth, input int sub, input logic [31:0] d);
        return {meth[12:0], sub[2:0], d};
    endfunction

    localparam int NS = 22;
    localparam int NE = 13;
    localparam logic [31:0] STREAM [NS] = '{
        H(1,3,2,'h100), A(1), A(2), A(3),
        H(0,2,1,'h1FFF), A(4), A(5),
        H(3,2,7,'h040), A(6), A(7),
        H(2,1,0,'h050), A(8),
        H(5,3,4,'h200), A(9), A(10), A(11),
        H(4,'h1ABC,3,'h300),
        H(1,0,5,'h010),
        H(5,0,5,'h010),
        H(6,2,1,'h020),
        H(7,1,1,'h020),
        H(4,5,6,'h007)};
    localparam logic [47:0] EXPECT [NE] = '{
        E('h100,2,A(1)), E('h101,2,A(2)), E('h102,2,A(3)),
        E('h1FFF,1,A(4)), E('h000,1,A(5)),
        E('h040,7,A(6)), E('h040,7,A(7)),
        E('h050,0,A(8)),
        E('h200,4,A(9)), E('h201,4,A(10)), E('h201,4,A(11)),
        E('h300,3,32'h0000_1ABC),
        E('h007,6,32'h0000_0005)};

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: samples just before each rising edge
    always begin
        @(negedge clk);
        #4;
        if (mon_en) begin
            if (out_valid && out_ready) got.push_back({out_method, out_subch, out_data});
            if (err_mode)  n_mode++;
            if (err_zero)  n_zero++;
            if (err_trunc) n_trunc++;
        end
    end

    task automatic clear_mon;
        got.delete();
        n_mode = 0; n_zero = 0; n_trunc = 0;
        mon_en = 1'b1;
    endtask

    task automatic feed(input int n, input int len, input bit bp);
        int k = 0;
        logic [15:0] lf = 16'hACE1;
        @(negedge clk);
        start = 1'b1; start_len = len[15:0];
        @(negedge clk);
        start = 1'b0;
        while (k < n) begin
            in_valid = 1'b1;
            in_data  = feed_q[k];
            if (bp) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                out_ready = lf[0];
            end else out_ready = 1'b1;
            #4;
            if (in_ready) k++;
            @(negedge clk);
        end
        in_valid = 1'b0; in_data = '0; out_ready = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic run_table(input bit bp, input string tag);
        clear_mon();
        feed_q.delete();
        for (int i = 0; i < NS; i++) feed_q.push_back(STREAM[i]);
        feed(NS, NS, bp);
        chk({"R5 R10 write count ", tag}, got.size(), NE);
        for (int i = 0; i < NE; i++) begin
            string r;
            if (i < 5)       r = "R1 increasing";
            else if (i < 8)  r = "R2 fixed method";
            else if (i < 11) r = "R3 step once";
            else             r = "R4 inline";
            chk({r, " ", tag}, (i < got.size()) ? got[i] : 48'hX, EXPECT[i]);
        end
        chk({"R6 zero-count flag ", tag}, n_zero, 1);
        chk({"R7 bad mode flags ", tag}, n_mode, 2);
        chk({"R9 no truncation ", tag}, n_trunc, 0);
        chk({"R8 busy clear ", tag}, busy, 0);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #4;
        // R11 reset state
        chk("R11 out_valid", out_valid, 0);
        chk("R11 in_ready", in_ready, 0);
        chk("R11 busy", busy, 0);
        chk("R11 flags", {err_mode, err_zero, err_trunc}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Vector table, no backpressure then pseudo-random backpressure
        run_table(1'b0, "ready");
        run_table(1'b1, "stall");

        // R8 zero-length start leaves block idle
        @(negedge clk); start = 1'b1; start_len = '0;
        @(negedge clk); start = 1'b0; #4;
        chk("R8 zero length idle", busy, 0);

        // R9 truncation inside arguments, R8 extra word refused
        clear_mon();
        feed_q.delete();
        feed_q.push_back(H(1,4,0,'h020)); feed_q.push_back(A(20)); feed_q.push_back(A(21));
        feed(3, 3, 1'b0);
        chk("R9 trunc write count", got.size(), 2);
        chk("R9 trunc write 0", got.size() > 0 ? got[0] : 48'hX, E('h020,0,A(20)));
        chk("R9 trunc write 1", got.size() > 1 ? got[1] : 48'hX, E('h021,0,A(21)));
        chk("R9 trunc flag", n_trunc, 1);
        in_valid = 1'b1; in_data = A(22);
        repeat (3) begin
            #4; chk("R8 beyond budget in_ready", in_ready, 0);
            @(negedge clk);
        end
        in_valid = 1'b0;
        chk("R8 no extra write", got.size(), 2);

        // R9 truncation on header as last word
        clear_mon();
        feed_q.delete();
        feed_q.push_back(H(0,2,3,'h030));
        feed(1, 1, 1'b0);
        chk("R9 header trunc writes", got.size(), 0);
        chk("R9 header trunc flag", n_trunc, 1);

        // R4 inline header as last word is complete
        clear_mon();
        feed_q.delete();
        feed_q.push_back(H(4,9,1,'h031));
        feed(1, 1, 1'b0);
        chk("R4 inline last write", got.size() > 0 ? got[0] : 48'hX, E('h031,1,32'd9));
        chk("R4 inline last no trunc", n_trunc, 0);

        // R10 explicit hold, then drain and refill in one cycle
        clear_mon();
        @(negedge clk); start = 1'b1; start_len = 16'd2;
        @(negedge clk); start = 1'b0;
        in_valid = 1'b1; in_data = H(4,'h0AA,2,'h044); out_ready = 1'b0;
        #4; chk("R10 first accepted", in_ready, 1);
        @(negedge clk);
        in_data = H(4,'h0BB,2,'h045);
        #4;
        chk("R10 held valid", out_valid, 1);
        chk("R10 stall input", in_ready, 0);
        @(negedge clk); #4;
        chk("R10 held data", {out_method, out_data}, {13'h044, 32'h0AA});
        @(negedge clk);
        out_ready = 1'b1;
        #4; chk("R10 refill same cycle", in_ready, 1);
        @(negedge clk);
        in_valid = 1'b0;
        #4; chk("R10 second write", {out_method, out_subch, out_data}, E('h045,2,32'h0BB));
        repeat (2) @(negedge clk);
        chk("R10 both writes once", got.size(), 2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule